// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides when an 8-bit microcontroller core takes a hardware call into an interrupt service routine, and which routine that is. It watches nine request flags, masks them with per-source enables and a global enable, and splits them into a low and a high priority level using two priority registers. A request can win only on the final cycle of an instruction. It cannot win during a return-from-interrupt, or while the enable and priority registers are being accessed. It is also held off while a routine of the same or a higher level is running.

Time is counted in machine cycles. The core marks the late phase of each machine cycle with a one-clock strobe. At that edge the controller latches the flags. At the same edge it makes its decision from the flags latched one strobe earlier, so every decision uses values that are one machine cycle old. A request that is refused is not remembered. On a win, the controller emits a single-clock call pulse with the 16-bit vector address and marks the winner's level as in service. A return-from-interrupt on its last cycle clears the highest level that is in service. A plain return leaves the in-service state untouched.

Top module: `irq_ctrl`

## Requirements
- R1: Flags are latched only on clocks where `mc_end` is high. The decision at an `mc_end` edge uses the flags latched at the previous `mc_end` edge. A flag first seen at one strobe produces its call after the next strobe, not the same one.
- R2: No pending state is kept. A request refused at one strobe is serviced later only if its flag is latched high again at a later strobe.
- R3: No call is issued at a strobe where `last_cyc` is low.
- R4: No call is issued at a strobe where `is_reti` or `reg_acc` is high.
- R5: While the high level is in service, no call is issued. While only the low level is in service, only a high-priority candidate may be called, which preempts the low routine.
- R6: Source indices 0..8 are external 0, timer 0, external 1, timer 1, serial 1, timer 2, USB, I2C and serial 2. Their vectors are 0003h, 000Bh, 0013h, 001Bh, 0023h, 002Bh, 0033h, 0043h and 004Bh respectively.
- R7: A high-priority candidate beats any low one. Within a level, the lowest source index wins.
- R8: A source is a candidate only if its own enable bit and the global enable bit are both 1.
- R9: A call is a one-clock pulse on `call_req`, with `call_vec` valid in the same clock. It sets the in-service flag of the winner's level.
- R10: A strobe with `last_cyc` and `is_reti` both high clears the high in-service flag if it is set; otherwise it clears the low one. A strobe with `last_cyc` high and `is_reti` low leaves both flags unchanged.
- R11: There are four registers, chosen by `reg_sel`.
  - Select 0 is enable A: bit 7 is the global enable, bits 5:0 enable sources 0..5, and bit 6 reads 0.
  - Select 1 is enable B: bit 0 enables USB, bit 1 enables I2C, bit 4 enables serial 2, and all other bits read 0.
  - Select 2 is priority A, with bits 5:0 for sources 0..5.
  - Select 3 is priority B, with the same layout as enable B.
  - A priority bit of 1 means high. Writes take effect when `reg_wr` is high. `reg_rdata` shows the selected register.
- R12: Reset clears all enables, all priorities, both in-service flags and `call_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_end | input | 1 | One-clock strobe at the late phase of each machine cycle |
| irq_flag | input | 9 | Raw request flags, indexed by source |
| last_cyc | input | 1 | Current machine cycle ends the instruction |
| is_reti | input | 1 | Current instruction is a return-from-interrupt |
| reg_acc | input | 1 | Current instruction accesses the enable or priority registers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| call_req | output | 1 | Hardware call pulse |
| call_vec | output | 16 | Vector address for the call |
| in_svc_lo | output | 1 | Low level in service |
| in_svc_hi | output | 1 | High level in service |

## Verification
The bench checks the one-strobe latency: a design that decides on freshly latched flags would call one machine cycle early. It holds a request across a blocked strobe and then drops it, so a design that remembers refused requests is caught servicing a ghost. It issues a plain return while the high level is in service, and a return-from-interrupt with both levels in service. A design that clears on any return, or clears the wrong level, then either reopens arbitration or blocks the preempted routine's level. It also writes all ones to every register, which exposes unused bits that do not read back as zero.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 9;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 16;
  localparam int DAT_W = 8;

  // vectors step by 8 from 0003h; the slot after USB is skipped
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] slot;
    slot = VEC_W'(idx);
    if (idx > IDX_W'(6)) slot = slot + VEC_W'(1);
    return VEC_W'(3) + (slot << 3);
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [DAT_W-1:0] wdata,
  output logic [DAT_W-1:0] rdata,
  output logic [NSRC-1:0]  en_vec,
  output logic             glob_en,
  output logic [NSRC-1:0]  prio_vec
);
  localparam logic [DAT_W-1:0] MASK_A = 8'hBF;
  localparam logic [DAT_W-1:0] MASK_B = 8'h13;
  localparam logic [DAT_W-1:0] MASK_PA = 8'h3F;

  logic [DAT_W-1:0] ena_a, ena_b, pri_a, pri_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_a <= '0;
      ena_b <= '0;
      pri_a <= '0;
      pri_b <= '0;
    end else if (wr) begin
      case (sel)
        2'd0: ena_a <= wdata & MASK_A;
        2'd1: ena_b <= wdata & MASK_B;
        2'd2: pri_a <= wdata & MASK_PA;
        default: pri_b <= wdata & MASK_B;
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'd0: rdata = ena_a;
      2'd1: rdata = ena_b;
      2'd2: rdata = pri_a;
      default: rdata = pri_b;
    endcase
  end

  assign glob_en  = ena_a[7];
  assign en_vec   = {ena_b[4], ena_b[1], ena_b[0], ena_a[5:0]};
  assign prio_vec = {pri_b[4], pri_b[1], pri_b[0], pri_a[5:0]};

  // R11: unused bits never hold a one
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((ena_a & ~MASK_A) == '0) && ((ena_b & ~MASK_B) == '0) && ((pri_b & ~MASK_B) == '0));
endmodule

// File: rtl/irq_poll.sv
module irq_poll
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_end,
  input  logic [NSRC-1:0]  irq_flag,
  input  logic [NSRC-1:0]  en_vec,
  input  logic             glob_en,
  input  logic [NSRC-1:0]  prio_vec,
  output logic             hi_any,
  output logic [IDX_W-1:0] hi_idx,
  output logic             lo_any,
  output logic [IDX_W-1:0] lo_idx
);
  logic [NSRC-1:0] samp;
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] cand_hi, cand_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      samp <= '0;
    else if (mc_end) samp <= irq_flag;
  end

  assign cand    = samp & en_vec & {NSRC{glob_en}};
  assign cand_hi = cand & prio_vec;
  assign cand_lo = cand & ~prio_vec;

  // lowest index wins: scan from top, later (lower) hits overwrite
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_hi[i]) hi_idx = IDX_W'(i);
      if (cand_lo[i]) lo_idx = IDX_W'(i);
    end
  end

  assign hi_any = |cand_hi;
  assign lo_any = |cand_lo;

  // R1: samples move only on the strobe
  a_r1_sample_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mc_end) |-> $stable(samp));
endmodule

// File: rtl/irq_level.sv
module irq_level
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_end,
  input  logic             last_cyc,
  input  logic             is_reti,
  input  logic             reg_acc,
  input  logic             hi_any,
  input  logic [IDX_W-1:0] hi_idx,
  input  logic             lo_any,
  input  logic [IDX_W-1:0] lo_idx,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             ins_lo,
  output logic             ins_hi
);
  logic gate_ok, take_hi, take_lo, ret_done;

  assign gate_ok  = last_cyc & ~is_reti & ~reg_acc;
  assign take_hi  = gate_ok & hi_any & ~ins_hi;
  assign take_lo  = gate_ok & ~take_hi & lo_any & ~ins_hi & ~ins_lo;
  assign ret_done = last_cyc & is_reti;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req <= 1'b0;
      call_vec <= '0;
      ins_lo   <= 1'b0;
      ins_hi   <= 1'b0;
    end else begin
      call_req <= 1'b0;
      if (mc_end) begin
        if (take_hi) begin
          call_req <= 1'b1;
          call_vec <= vec_of(hi_idx);
          ins_hi   <= 1'b1;
        end else if (take_lo) begin
          call_req <= 1'b1;
          call_vec <= vec_of(lo_idx);
          ins_lo   <= 1'b1;
        end
        if (ret_done) begin
          if (ins_hi) ins_hi <= 1'b0;
          else        ins_lo <= 1'b0;
        end
      end
    end
  end

  // R9: call lasts one clock
  a_r9_call_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);
  // R3: call only after a final-cycle strobe
  a_r3_last_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(mc_end && last_cyc));
  // R4: never on return-from-interrupt or register access
  a_r4_blocked_status: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(is_reti) && !$past(reg_acc));
  // R5: nothing preempts the high level
  a_r5_high_busy: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(ins_hi));
  // R10: in-service flags fall only on a return-from-interrupt strobe
  a_r10_clear_on_reti: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ins_hi) || $fell(ins_lo)) |-> $past(mc_end && is_reti && last_cyc));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mc_end,
  input  logic [8:0]  irq_flag,
  input  logic        last_cyc,
  input  logic        is_reti,
  input  logic        reg_acc,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        call_req,
  output logic [15:0] call_vec,
  output logic        in_svc_lo,
  output logic        in_svc_hi
);
  logic [NSRC-1:0]  en_vec, prio_vec;
  logic             glob_en;
  logic             hi_any, lo_any;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_vec(en_vec), .glob_en(glob_en), .prio_vec(prio_vec)
  );

  irq_poll u_poll (
    .clk(clk), .rst_n(rst_n), .mc_end(mc_end), .irq_flag(irq_flag),
    .en_vec(en_vec), .glob_en(glob_en), .prio_vec(prio_vec),
    .hi_any(hi_any), .hi_idx(hi_idx), .lo_any(lo_any), .lo_idx(lo_idx)
  );

  irq_level u_level (
    .clk(clk), .rst_n(rst_n), .mc_end(mc_end), .last_cyc(last_cyc),
    .is_reti(is_reti), .reg_acc(reg_acc),
    .hi_any(hi_any), .hi_idx(hi_idx), .lo_any(lo_any), .lo_idx(lo_idx),
    .call_req(call_req), .call_vec(call_vec), .ins_lo(in_svc_lo), .ins_hi(in_svc_hi)
  );

  // R12: idle after reset
  a_r12_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> !call_req && !in_svc_lo && !in_svc_hi);
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mc_end = 1'b0;
  logic [8:0]  irq_flag = '0;
  logic        last_cyc = 1'b1;
  logic        is_reti = 1'b0;
  logic        reg_acc = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        call_req;
  logic [15:0] call_vec;
  logic        in_svc_lo, in_svc_hi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // R6: {source index, vector}
  localparam logic [19:0] VTAB [9] = '{
    {4'd0, 16'h0003}, {4'd1, 16'h000B}, {4'd2, 16'h0013},
    {4'd3, 16'h001B}, {4'd4, 16'h0023}, {4'd5, 16'h002B},
    {4'd6, 16'h0033}, {4'd7, 16'h0043}, {4'd8, 16'h004B}};

  localparam logic [8:0] EX0 = 9'h001, T0 = 9'h002, EX1 = 9'h004, T1 = 9'h008;
  localparam logic [8:0] USB = 9'h040, SER2 = 9'h100;

  irq_ctrl uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // one machine cycle: four clocks, strobe on the last
  task automatic mcyc(input logic [8:0] f, input logic last, input logic ret, input logic acc);
    irq_flag = f; last_cyc = last; is_reti = ret; reg_acc = acc; mc_end = 1'b0;
    repeat (3) @(negedge clk);
    mc_end = 1'b1;
    @(negedge clk);
    mc_end = 1'b0; last_cyc = 1'b1; is_reti = 1'b0; reg_acc = 1'b0;
  endtask

  task automatic reti_cyc();
    mcyc('0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 call", call_req, 0);
    chk("R12 svc", {in_svc_hi, in_svc_lo}, 0);
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s); #1;
      chk("R12 reg", reg_rdata, 0);
    end
    wr(0, 8'hBF); wr(1, 8'h13);

    // table walk: R6 vectors, each at low level
    for (int i = 0; i < 9; i++) begin
      mcyc(9'(1) << VTAB[i][19:16], 1, 0, 0);
      chk("R1 early", call_req, 0);
      mcyc('0, 1, 0, 0);
      chk("R9 call", call_req, 1);
      chk("R6 vector", call_vec, VTAB[i][15:0]);
      chk("R9 lo set", in_svc_lo, 1);
      @(negedge clk);
      chk("R9 pulse", call_req, 0);
      reti_cyc();
      chk("R10 lo clr", in_svc_lo, 0);
    end

    // R1: flag gone before strobe never sampled
    irq_flag = EX0; repeat (3) @(negedge clk);
    irq_flag = '0; mc_end = 1'b1; @(negedge clk); mc_end = 1'b0;
    mcyc('0, 1, 0, 0);
    chk("R1 unsampled", call_req, 0);

    // R3 and R2: blocked then flag dropped
    mcyc(T0, 1, 0, 0);
    mcyc('0, 0, 0, 0);
    chk("R3 not last", call_req, 0);
    mcyc('0, 1, 0, 0);
    chk("R2 forgotten", call_req, 0);
    // flag held: serviced once unblocked
    mcyc(T0, 1, 0, 0);
    mcyc(T0, 0, 0, 0);
    chk("R3 not last", call_req, 0);
    mcyc('0, 1, 0, 0);
    chk("R3 later", call_vec, 16'h000B);
    reti_cyc();

    // R4
    mcyc(T1, 1, 0, 0);
    mcyc(T1, 1, 1, 0);
    chk("R4 reti", call_req, 0);
    mcyc(T1, 1, 0, 1);
    chk("R4 regacc", call_req, 0);
    mcyc('0, 1, 0, 0);
    chk("R4 after", {call_req, call_vec}, {1'b1, 16'h001B});
    reti_cyc();

    // R8
    wr(0, 8'h3F);
    mcyc(EX0, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R8 global off", call_req, 0);
    wr(0, 8'hBE);
    mcyc(EX0, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R8 own off", call_req, 0);
    wr(0, 8'hBF);

    // R7 fixed order
    mcyc(EX1 | T1 | SER2, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R7 order", call_vec, 16'h0013);
    reti_cyc();

    // R7 high beats low, R5 high blocks all, R10 plain return
    wr(3, 8'h10);
    mcyc(T0 | SER2, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R7 high wins", call_vec, 16'h004B);
    chk("R9 hi set", {in_svc_hi, in_svc_lo}, 2'b10);
    mcyc(T0, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R5 low blocked", call_req, 0);
    wr(3, 8'h11);
    mcyc(USB, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R5 same blocked", call_req, 0);
    mcyc('0, 1, 0, 0);
    chk("R10 plain ret", in_svc_hi, 1);
    reti_cyc();
    chk("R10 hi clr", in_svc_hi, 0);

    // R5 preemption, R10 order of clearing
    mcyc(T0, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R5 low in", {in_svc_hi, in_svc_lo}, 2'b01);
    mcyc(SER2, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R5 preempt", {call_req, call_vec}, {1'b1, 16'h004B});
    reti_cyc();
    chk("R10 hi first", {in_svc_hi, in_svc_lo}, 2'b01);
    mcyc(T0, 1, 0, 0); mcyc('0, 1, 0, 0);
    chk("R5 lo busy", call_req, 0);
    reti_cyc();
    chk("R10 lo next", {in_svc_hi, in_svc_lo}, 2'b00);

    // R11 register map
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF);
    reg_sel = 2'd0; #1; chk("R11 enA", reg_rdata, 8'hBF);
    reg_sel = 2'd1; #1; chk("R11 enB", reg_rdata, 8'h13);
    reg_sel = 2'd2; #1; chk("R11 prA", reg_rdata, 8'h3F);
    reg_sel = 2'd3; #1; chk("R11 prB", reg_rdata, 8'h13);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule